// File: doc/BRIEF.md
# Digit-serial Montgomery modular multiplier

This block computes the Montgomery product S = X·Y·R⁻¹ mod N on operands of NDIG digits, each digit 32 bits wide, with R = 2^(32·NDIG). X, Y and N are loaded one digit at a time into three local digit memories through a single load port. The constant nprime = −N[0]⁻¹ mod 2³² is supplied as an input. The top digit of N must be zero. X and Y may lie anywhere in [0, 2N). Because R exceeds N by a full digit, the result also lands in [0, 2N) and no final subtraction of N is made. The result can therefore be fed straight back as an operand for a following product.

A start pulse runs one product. The outer loop walks the digits of X from least significant upward. At the start of each outer iteration, state QCALC computes the quotient digit q = ((S[0] + X[i]·Y[0])·nprime) mod 2³² and clears both carry groups. The inner loop then alternates two states for j = 0 … NDIG. State HSTEP forms H[j] = X[i]·Y[j] + S[j] plus the carries held from digit j−1. State WSTEP forms W[j] = q·N[j] + H[j] plus its own carries. The last inner step, j = NDIG, reads zero digits and only empties the carries.

Digits W[1..NDIG] are the next partial result. They are pushed into a small digit FIFO and read back during the next outer iteration. On the final outer iteration they are written into the result register instead. The FSM states and transitions are:
- IDLE→QCALC on start.
- QCALC→HSTEP always.
- HSTEP→WSTEP always.
- WSTEP→HSTEP while j < NDIG.
- WSTEP→QCALC when j = NDIG and another outer iteration remains.
- WSTEP→IDLE when j = NDIG on the last outer iteration. A one-cycle done pulse is raised here.

Top module: `mont_mul_top`

## Requirements
- R1: After reset, busy and done are 0 and result is all zeros.
- R2: For odd N whose top digit is zero, and X, Y in [0, 2N), result equals (X·Y + M·N)/R. Here M is the unique value in [0, R) that makes X·Y + M·N divisible by R, so result ≡ X·Y·R⁻¹ (mod N).
- R3: No final subtraction is made. Every result is below 2N, and a result may exceed N−1.
- R4: done is a single-cycle pulse. It rises exactly NDIG·(2·NDIG+3) clock edges after the edge that accepts start (27 edges for NDIG = 3).
- R5: busy is 1 from the edge after start is accepted until done. A start pulse while busy is ignored and does not change the timing or the value of the running product.
- R6: result changes only during a product. While busy is 0 it holds its value.
- R7: Load writes are accepted only while the block is idle. A load write while busy leaves the stored digits unchanged.
- R8: Load select code 0 writes X, code 1 writes Y, code 2 writes N, and code 3 writes nothing. ld_addr is the digit index, with 0 being the least significant digit.
- R9: Boundary operands are handled: X = 0 gives result 0, and X = Y = 2N−1 gives the exact value of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Digit load strobe |
| ld_sel | input | 2 | Load target: 0 X, 1 Y, 2 N, 3 none |
| ld_addr | input | $clog2(NDIG) | Digit index to load |
| ld_data | input | 32 | Digit value |
| nprime | input | 32 | −N[0]⁻¹ mod 2³² |
| start | input | 1 | Begin one product (pulse) |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32·NDIG | Result digits, least significant digit in bits 31:0 |

## Verification
The bench builds the block with NDIG = 3, so the moduli are up to 64 bits wide inside 96-bit operands. This is small enough that the exact Montgomery value can be computed bit-serially with wide integers in the bench. It is also large enough that the carry groups ripple across several digits and the FIFO turns over several times per product. The chosen moduli cover a tiny modulus, a modulus with a one-bit low digit, and a full 64-bit modulus. The boundary operands 0 and 2N−1 bring both the zero result and results above N within reach. Disturbed runs, with a start and a load write issued while busy, and an idle write with select code 3, are each followed by a rerun without reloading. This exposes any stray write to the operand memories.

// File: rtl/mont_pkg.sv
package mont_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QCALC,
        ST_HSTEP,
        ST_WSTEP
    } mstate_t;

    localparam logic [1:0] SEL_X = 2'd0;
    localparam logic [1:0] SEL_Y = 2'd1;
    localparam logic [1:0] SEL_N = 2'd2;
endpackage

// File: rtl/mont_digit_mem.sv
module mont_digit_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 3,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we && (32'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (32'(raddr) < DEPTH) rdata = mem[raddr];
    end
endmodule

// File: rtl/mont_digit_fifo.sv
module mont_digit_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 3,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/mont_mac_stage.sv
module mont_mac_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] addend,
    output logic [DW-1:0] sum
);
    logic [2*DW-1:0] prod;
    logic [DW:0]     t1, t2;
    logic [DW-1:0]   hi_q;
    logic            c1_q, c2_q;

    always_comb begin
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        t1   = {1'b0, prod[DW-1:0]} + {1'b0, hi_q} + {{DW{1'b0}}, c1_q};
        t2   = {1'b0, t1[DW-1:0]} + {1'b0, addend} + {{DW{1'b0}}, c2_q};
        sum  = t2[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hi_q <= '0;
            c1_q <= 1'b0;
            c2_q <= 1'b0;
        end else if (en) begin
            hi_q <= prod[2*DW-1:DW];
            c1_q <= t1[DW];
            c2_q <= t2[DW];
        end
    end
endmodule

// File: rtl/mont_mul_top.sv
module mont_mul_top
    import mont_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NDIG = 3,
    localparam int AW  = $clog2(NDIG),
    localparam int JW  = $clog2(NDIG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [1:0]       ld_sel,
    input  logic [AW-1:0]    ld_addr,
    input  logic [DW-1:0]    ld_data,
    input  logic [DW-1:0]    nprime,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [DW*NDIG-1:0] result
);
    localparam logic [JW-1:0] J_LAST = JW'(NDIG);
    localparam logic [AW-1:0] I_LAST = AW'(NDIG - 1);

    mstate_t state_q, state_d;
    logic [AW-1:0] i_q;
    logic [JW-1:0] j_q;
    logic          first_q;
    logic [DW-1:0] q_q, h_q;
    logic          done_q;
    logic [DW*NDIG-1:0] res_q;

    // control strobes from the output process
    logic clr_c, en_a, en_b, pop_c, push_c, res_we, q_ld, flush_c, fin_c;

    // digit memories
    logic [DW-1:0] mem_rd [3];
    logic [AW-1:0] mem_ra [3];
    logic          j_in;
    logic [AW-1:0] j_addr;

    assign j_in   = (j_q < J_LAST);
    assign j_addr = j_q[AW-1:0];

    for (genvar g = 0; g < 3; g++) begin : g_mem
        assign mem_ra[g] = (g == 0) ? i_q : j_addr;
        mont_digit_mem #(.DW(DW), .DEPTH(NDIG), .AW(AW)) u_mem (
            .clk   (clk),
            .rst   (rst),
            .we    (ld_en && (state_q == ST_IDLE) && (ld_sel == 2'(g))),
            .waddr (ld_addr),
            .wdata (ld_data),
            .raddr (mem_ra[g]),
            .rdata (mem_rd[g])
        );
    end

    logic [DW-1:0] x_i, y_j, n_j;
    assign x_i = mem_rd[SEL_X];
    assign y_j = j_in ? mem_rd[SEL_Y] : '0;
    assign n_j = j_in ? mem_rd[SEL_N] : '0;

    // partial-result FIFO
    logic [DW-1:0] fifo_head, w_sum, h_sum, s_j, s0, hq, q_next;

    mont_digit_fifo #(.DW(DW), .DEPTH(NDIG), .AW(AW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_c),
        .push  (push_c),
        .pop   (pop_c),
        .din   (w_sum),
        .head  (fifo_head)
    );

    assign s0     = first_q ? '0 : fifo_head;
    assign s_j    = (first_q || !j_in) ? '0 : fifo_head;
    assign hq     = s0 + (x_i * y_j);
    assign q_next = hq * nprime;

    mont_mac_stage #(.DW(DW)) u_stage_h (
        .clk (clk), .rst (rst), .clr (clr_c), .en (en_a),
        .a (x_i), .b (y_j), .addend (s_j), .sum (h_sum)
    );

    mont_mac_stage #(.DW(DW)) u_stage_w (
        .clk (clk), .rst (rst), .clr (clr_c), .en (en_b),
        .a (q_q), .b (n_j), .addend (h_q), .sum (w_sum)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_QCALC;
            ST_QCALC: state_d = ST_HSTEP;
            ST_HSTEP: state_d = ST_WSTEP;
            ST_WSTEP: begin
                if (j_q != J_LAST)      state_d = ST_HSTEP;
                else if (i_q == I_LAST) state_d = ST_IDLE;
                else                    state_d = ST_QCALC;
            end
        endcase
    end

    // outputs (control strobes)
    always_comb begin
        clr_c   = 1'b0;
        en_a    = 1'b0;
        en_b    = 1'b0;
        pop_c   = 1'b0;
        push_c  = 1'b0;
        res_we  = 1'b0;
        q_ld    = 1'b0;
        flush_c = 1'b0;
        fin_c   = 1'b0;
        unique case (state_q)
            ST_IDLE:  flush_c = start;
            ST_QCALC: begin
                clr_c = 1'b1;
                q_ld  = 1'b1;
            end
            ST_HSTEP: begin
                en_a  = 1'b1;
                pop_c = !first_q && j_in;
            end
            ST_WSTEP: begin
                en_b   = 1'b1;
                push_c = (j_q != '0) && (i_q != I_LAST);
                res_we = (j_q != '0) && (i_q == I_LAST);
                fin_c  = (j_q == J_LAST) && (i_q == I_LAST);
            end
        endcase
    end

    // loop counters and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            i_q     <= '0;
            j_q     <= '0;
            first_q <= 1'b1;
            q_q     <= '0;
            h_q     <= '0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= fin_c;
            if (q_ld) q_q <= q_next;
            if (en_a) h_q <= h_sum;
            if (state_q == ST_IDLE && start) begin
                i_q     <= '0;
                j_q     <= '0;
                first_q <= 1'b1;
            end else if (state_q == ST_WSTEP) begin
                if (j_q != J_LAST) begin
                    j_q <= j_q + 1'b1;
                end else begin
                    j_q     <= '0;
                    first_q <= 1'b0;
                    if (i_q != I_LAST) i_q <= i_q + 1'b1;
                end
            end
            for (int k = 0; k < NDIG; k++) begin
                if (res_we && (j_q == JW'(k + 1))) res_q[k*DW +: DW] <= w_sum;
            end
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = res_q;
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
    parameter int DW   = 32,
    parameter int NDIG = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [DW*NDIG-1:0] result
);
    localparam int TOT = NDIG * (2 * NDIG + 3);

    logic [31:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (start && !busy) cnt <= '0;
        else if (busy)           cnt <= cnt + 1;
    end

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_cycles_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == 32'(TOT)));

    p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(result));
endmodule

bind mont_mul_top mont_mul_chk #(.DW(DW), .NDIG(NDIG)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/mont_mul_top_bench.sv
`timescale 1ns/1ps
module mont_mul_top_bench;
    localparam int DW   = 32;
    localparam int NDIG = 3;
    localparam int AW   = $clog2(NDIG);
    localparam int WB   = DW * NDIG;
    localparam int TOT  = NDIG * (2 * NDIG + 3);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_sel = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] nprime = '0;
    logic          start = 1'b0;
    logic          busy, done;
    logic [WB-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int st_cyc  = 0;
    bit finished = 1'b0;
    bit prev_done = 1'b0;

    logic [WB-1:0] exp_res [$];
    logic [WB-1:0] exp_mod [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mont_mul_top #(.DW(DW), .NDIG(NDIG)) u_mont_mul_top (
        .clk (clk), .rst (rst), .ld_en (ld_en), .ld_sel (ld_sel),
        .ld_addr (ld_addr), .ld_data (ld_data), .nprime (nprime),
        .start (start), .busy (busy), .done (done), .result (result)
    );

    task automatic chk(input bit ok, input string req, input logic [WB:0] act, input logic [WB:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [WB-1:0] mont_ref(input logic [WB-1:0] x, input logic [WB-1:0] y,
                                               input logic [WB-1:0] n);
        logic [255:0] t;
        t = 256'(x) * 256'(y);
        for (int k = 0; k < WB; k++) begin
            if (t[k]) t = t + (256'(n) << k);
        end
        return WB'(t >> WB);
    endfunction

    function automatic logic [DW-1:0] calc_np(input logic [DW-1:0] n0);
        logic [DW-1:0] inv;
        inv = n0;
        for (int k = 0; k < 5; k++) inv = inv * (32'd2 - n0 * inv);
        return -inv;
    endfunction

    task automatic load_num(input logic [1:0] sel, input logic [WB-1:0] v);
        for (int k = 0; k < NDIG; k++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_sel  = sel;
            ld_addr = AW'(k);
            ld_data = v[k*DW +: DW];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // driver: loads operands, pushes expectation, starts the product
    task automatic run_case(input logic [WB-1:0] x, input logic [WB-1:0] y,
                            input logic [WB-1:0] n, input bit do_load, input bit disturb);
        if (do_load) begin
            load_num(2'd0, x);
            load_num(2'd1, y);
            load_num(2'd2, n);
        end
        nprime = calc_np(n[DW-1:0]);
        exp_res.push_back(mont_ref(x, y, n));
        exp_mod.push_back(n);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 st_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R5 busy after start", (WB+1)'(busy), (WB+1)'(1));
        if (disturb) begin
            repeat (4) @(negedge clk);
            start   = 1'b1;
            ld_en   = 1'b1;
            ld_sel  = 2'd0;
            ld_addr = '0;
            ld_data = 32'hDEAD_BEEF;
            @(negedge clk);
            start = 1'b0;
            ld_en = 1'b0;
        end
        wait (exp_res.size() == 0);
        @(negedge clk);
        chk(busy == 1'b0, "R5 idle after done", (WB+1)'(busy), (WB+1)'(0));
    endtask

    // monitor: compares results as the design completes them
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done)
                chk(done == 1'b0, "R4 done pulse width", (WB+1)'(done), (WB+1)'(0));
            if (done && exp_res.size() != 0) begin
                logic [WB-1:0] e, nm;
                e  = exp_res.pop_front();
                nm = exp_mod.pop_front();
                chk(result == e, "R2 product value", (WB+1)'(result), (WB+1)'(e));
                chk({1'b0, result} < ({1'b0, nm} << 1), "R3 result below 2N",
                    (WB+1)'(result), ({1'b0, nm} << 1));
                chk(cyc == st_cyc + TOT, "R4 done latency", (WB+1)'(cyc - st_cyc), (WB+1)'(TOT));
            end
        end
        prev_done = done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [WB-1:0] na, nb, nc, hold;
        na = {32'h0, 64'hF123_4567_89AB_CDEF};
        nb = {32'h0, 64'h8000_0000_0000_0001};
        nc = WB'(3);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", (WB+1)'({busy, done}), (WB+1)'(0));
        chk(result == '0, "R1 reset result", (WB+1)'(result), (WB+1)'(0));

        run_case(WB'(5), WB'(7), na, 1'b1, 1'b0);                        // R2 small operands
        run_case(WB'(0), {32'h0, 64'h1234_5678_9ABC_DEF0}, na, 1'b1, 1'b0); // R9 zero operand
        chk(result == '0, "R9 zero operand", (WB+1)'(result), (WB+1)'(0));
        run_case((na << 1) - 1, (na << 1) - 1, na, 1'b1, 1'b0);           // R9 upper boundary
        run_case({32'h0, 64'hFFFF_FFFF_0000_0001}, {32'h0, 64'h7777_8888_9999_AAAB}, nb, 1'b1, 1'b0);
        run_case(WB'(5), WB'(4), nc, 1'b1, 1'b0);                         // R3 tiny modulus
        run_case((nb << 1) - 3, WB'(2), nb, 1'b1, 1'b0);

        // R5 and R7: start and load write while busy are ignored
        run_case({32'h0, 64'h0BAD_F00D_1357_9BDF}, {32'h0, 64'h2468_ACE0_1357_9BDF}, na, 1'b1, 1'b1);
        hold = result;
        run_case({32'h0, 64'h0BAD_F00D_1357_9BDF}, {32'h0, 64'h2468_ACE0_1357_9BDF}, na, 1'b0, 1'b0);
        chk(result == hold, "R7 busy write ignored", (WB+1)'(result), (WB+1)'(hold));

        // R8: select code 3 writes nothing
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd3; ld_addr = '0; ld_data = 32'hFFFF_FFFF;
        @(negedge clk);
        ld_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(result == hold, "R6 result held while idle", (WB+1)'(result), (WB+1)'(hold));
        run_case({32'h0, 64'h0BAD_F00D_1357_9BDF}, {32'h0, 64'h2468_ACE0_1357_9BDF}, na, 1'b0, 1'b0);
        chk(result == hold, "R8 select 3 ignored", (WB+1)'(result), (WB+1)'(hold));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule